// File: doc/BRIEF.md
# Software Interrupt Opcode Classifier

This block sits at the front of a simple in-order instruction decoder. It takes in the instruction byte stream one byte per valid cycle and picks out the two software-interrupt encodings. The first is the one-byte breakpoint, 0xCC. The second is the two-byte generic interrupt, 0xCD followed by a vector byte. For each complete instruction it reports one of three outcomes:

- a trap request with its vector number;
- a general-protection fault, when the two-byte form fails the I/O privilege check;
- a plain "not an interrupt" result for any other opcode byte.

In every case it also reports the instruction length.

The breakpoint behaves exactly like the two-byte form with vector 3, except that it is never privilege-checked. The two-byte form is checked in protected and virtual-8086 modes and never in real mode. The trap is reported once the instruction is complete. Descriptor lookup, stack pushes and the control transfer belong to later stages.

Top module: `swint_classifier`

## Requirements
- R1: After reset, and in every cycle where `out_valid` is low, `out_valid`, `out_trap`, `out_gp`, `out_vector` and `out_len` are all zero.
- R2: A valid byte 0xCC at an instruction boundary gives `out_valid`=1, `out_trap`=1, `out_gp`=0, `out_vector`=3 and `out_len`=1 in the next cycle, whatever the privilege levels and mode are.
- R3: A valid byte 0xCD at an instruction boundary is followed by a vector byte. The result appears in the cycle after that vector byte arrives, with `out_len`=2. When it is not faulted, `out_trap`=1 and `out_vector` equals the vector byte.
- R4: `mode` is encoded as 00 real, 01 protected, 10 virtual-8086, and 11 is handled as protected. For the two-byte form outside real mode, `cpl` > `iopl` (unsigned) gives `out_gp`=1, `out_trap`=0 and `out_vector`=0. Otherwise the trap is raised.
- R5: In real mode (`mode`=00) the two-byte form never raises `out_gp`, for any `cpl`/`iopl`.
- R6: While the vector byte of a 0xCD is outstanding, `out_valid` stays low. Cycles with `in_valid` low neither complete nor cancel the instruction.
- R7: Any other valid byte at an instruction boundary gives `out_valid`=1, `out_trap`=0, `out_gp`=0, `out_vector`=0 and `out_len`=1 in the next cycle.
- R8: The privilege check of the two-byte form uses the `cpl`, `iopl` and `mode` present with the 0xCD byte. Changes to them while the block waits for the vector byte have no effect.
- R9: `out_trap` and `out_gp` are never high together, and `out_valid` is high for exactly one cycle per completed instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | `in_byte` holds the next stream byte |
| in_byte | input | 8 | Instruction stream byte |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| mode | input | 2 | Operating mode: 00 real, 01 protected, 10 virtual-8086 |
| out_valid | output | 1 | One-cycle pulse: a classified instruction is reported |
| out_trap | output | 1 | Software-interrupt trap requested |
| out_vector | output | 8 | Trap vector number |
| out_len | output | 2 | Instruction length in bytes |
| out_gp | output | 1 | General-protection fault instead of the trap |

## Verification
The breakpoint is sent under a privilege setting that would fault the two-byte form, which shows that it skips the check. The two-byte form is swept over all sixteen `cpl`/`iopl` pairs in protected mode. A narrower set of pairs is then run in virtual-8086 and real mode, which separates the mode gating from the level comparison itself. Gaps between the two bytes show the stall, and changes to the privilege inputs inside such a gap show that the opcode-time sample is the one used. Unrelated bytes, including a second 0xCD used as a vector, show that only the instruction boundary is decoded.

// File: rtl/swint_classifier.sv
module swint_classifier #(
  parameter logic [7:0] BRK_OPCODE = 8'hCC,
  parameter logic [7:0] INT_OPCODE = 8'hCD,
  parameter logic [7:0] BRK_VECTOR = 8'd3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic [1:0] cpl,
  input  logic [1:0] iopl,
  input  logic [1:0] mode,
  output logic       out_valid,
  output logic       out_trap,
  output logic [7:0] out_vector,
  output logic [1:0] out_len,
  output logic       out_gp
);

  localparam logic [1:0] MODE_REAL = 2'b00;

  logic wait_imm;
  logic priv_fail_q;
  logic priv_fail_now;

  assign priv_fail_now = (mode != MODE_REAL) && (cpl > iopl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_imm    <= 1'b0;
      priv_fail_q <= 1'b0;
      out_valid   <= 1'b0;
      out_trap    <= 1'b0;
      out_gp      <= 1'b0;
      out_vector  <= 8'd0;
      out_len     <= 2'd0;
    end else begin
      out_valid  <= 1'b0;
      out_trap   <= 1'b0;
      out_gp     <= 1'b0;
      out_vector <= 8'd0;
      out_len    <= 2'd0;
      if (in_valid) begin
        if (wait_imm) begin
          wait_imm  <= 1'b0;
          out_valid <= 1'b1;
          out_len   <= 2'd2;
          if (priv_fail_q) begin
            out_gp <= 1'b1;
          end else begin
            out_trap   <= 1'b1;
            out_vector <= in_byte;
          end
        end else if (in_byte == BRK_OPCODE) begin
          out_valid  <= 1'b1;
          out_trap   <= 1'b1;
          out_vector <= BRK_VECTOR;
          out_len    <= 2'd1;
        end else if (in_byte == INT_OPCODE) begin
          wait_imm    <= 1'b1;
          priv_fail_q <= priv_fail_now;
        end else begin
          out_valid <= 1'b1;
          out_len   <= 2'd1;
        end
      end
    end
  end

endmodule

module swint_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input logic       wait_imm,
  input logic       out_valid,
  input logic       out_trap,
  input logic [7:0] out_vector,
  input logic [1:0] out_len,
  input logic       out_gp
);

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_trap && !out_gp && out_vector == 8'd0 && out_len == 2'd0));

  assert_brk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wait_imm && in_byte == 8'hCC) |=>
      (out_valid && out_trap && !out_gp && out_vector == 8'd3 && out_len == 2'd1));

  assert_imm_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wait_imm) |=>
      (out_valid && out_len == 2'd2 && (out_trap || out_gp) &&
       (!out_trap || out_vector == $past(in_byte))));

  assert_gp_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_gp |-> (out_len == 2'd2 && out_vector == 8'd0));

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_imm && !in_valid) |=> (!out_valid && wait_imm));

  assert_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wait_imm && in_byte != 8'hCC && in_byte != 8'hCD) |=>
      (out_valid && !out_trap && !out_gp && out_len == 2'd1));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_trap && out_gp));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |=> !out_valid);

endmodule

bind swint_classifier swint_classifier_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_byte    (in_byte),
  .wait_imm   (wait_imm),
  .out_valid  (out_valid),
  .out_trap   (out_trap),
  .out_vector (out_vector),
  .out_len    (out_len),
  .out_gp     (out_gp)
);

// File: tb/tb_swint_classifier.sv
`timescale 1ns/1ps
module tb_swint_classifier;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'd0;
  logic [1:0] cpl = 2'd0;
  logic [1:0] iopl = 2'd0;
  logic [1:0] mode = 2'd0;
  logic       out_valid;
  logic       out_trap;
  logic [7:0] out_vector;
  logic [1:0] out_len;
  logic       out_gp;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  swint_classifier dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .cpl(cpl), .iopl(iopl), .mode(mode),
    .out_valid(out_valid), .out_trap(out_trap), .out_vector(out_vector),
    .out_len(out_len), .out_gp(out_gp)
  );

  task automatic expect_out(input string tag, input logic v, input logic t,
                            input logic g, input logic [7:0] vec, input logic [1:0] len);
    total++;
    if (out_valid !== v || out_trap !== t || out_gp !== g ||
        out_vector !== vec || out_len !== len) begin
      bad++;
      $display("FAIL %s: got v=%0b t=%0b gp=%0b vec=%0d len=%0d exp v=%0b t=%0b gp=%0b vec=%0d len=%0d",
               tag, out_valid, out_trap, out_gp, out_vector, out_len, v, t, g, vec, len);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle(2);
    expect_out("R1 reset", 0, 0, 0, 8'd0, 2'd0);
    rst_n = 1'b1;
    idle(1);
    expect_out("R1 idle", 0, 0, 0, 8'd0, 2'd0);
  endtask

  task automatic t_breakpoint;
    cpl = 2'd3; iopl = 2'd0; mode = 2'b01;
    send(8'hCC);
    expect_out("R2 brk prot", 1, 1, 0, 8'd3, 2'd1);
    idle(1);
    expect_out("R9 pulse", 0, 0, 0, 8'd0, 2'd0);
    mode = 2'b10;
    send(8'hCC);
    expect_out("R2 brk v86", 1, 1, 0, 8'd3, 2'd1);
  endtask

  task automatic t_prot_sweep;
    mode = 2'b01;
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 4; p++) begin
        cpl = 2'(c); iopl = 2'(p);
        send(8'hCD);
        expect_out("R6 wait", 0, 0, 0, 8'd0, 2'd0);
        send(8'(16 * c + p + 32));
        if (c > p) expect_out("R4 prot gp", 1, 0, 1, 8'd0, 2'd2);
        else       expect_out("R3 prot trap", 1, 1, 0, 8'(16 * c + p + 32), 2'd2);
      end
    end
    mode = 2'b11;
    cpl = 2'd2; iopl = 2'd1;
    send(8'hCD); send(8'h40);
    expect_out("R4 mode11 gp", 1, 0, 1, 8'd0, 2'd2);
  endtask

  task automatic t_v86_real;
    mode = 2'b10; cpl = 2'd3; iopl = 2'd2;
    send(8'hCD); send(8'h21);
    expect_out("R4 v86 gp", 1, 0, 1, 8'd0, 2'd2);
    iopl = 2'd3;
    send(8'hCD); send(8'h21);
    expect_out("R4 v86 ok", 1, 1, 0, 8'h21, 2'd2);
    mode = 2'b00;
    for (int c = 1; c < 4; c++) begin
      cpl = 2'(c); iopl = 2'd0;
      send(8'hCD); send(8'h10);
      expect_out("R5 real", 1, 1, 0, 8'h10, 2'd2);
    end
    send(8'hCD); send(8'h03);
    expect_out("R3 int3 alias", 1, 1, 0, 8'd3, 2'd2);
  endtask

  task automatic t_stall;
    mode = 2'b01; cpl = 2'd0; iopl = 2'd0;
    send(8'hCD);
    for (int i = 0; i < 4; i++) begin
      expect_out("R6 stall", 0, 0, 0, 8'd0, 2'd0);
      @(negedge clk);
    end
    send(8'hCD);
    expect_out("R6 cd as vector", 1, 1, 0, 8'hCD, 2'd2);
    send(8'hCC);
    expect_out("R2 after stall", 1, 1, 0, 8'd3, 2'd1);
  endtask

  task automatic t_sample_hold;
    mode = 2'b01; cpl = 2'd0; iopl = 2'd3;
    send(8'hCD);
    cpl = 2'd3; iopl = 2'd0;
    idle(2);
    send(8'h80);
    expect_out("R8 held pass", 1, 1, 0, 8'h80, 2'd2);
    send(8'hCD);
    cpl = 2'd0; iopl = 2'd3; mode = 2'b00;
    send(8'h81);
    expect_out("R8 held fail", 1, 0, 1, 8'd0, 2'd2);
  endtask

  task automatic t_other;
    send(8'h90);
    expect_out("R7 nop", 1, 0, 0, 8'd0, 2'd1);
    send(8'hCE);
    expect_out("R7 CE", 1, 0, 0, 8'd0, 2'd1);
    send(8'h00);
    expect_out("R7 zero", 1, 0, 0, 8'd0, 2'd1);
    idle(1);
    expect_out("R1 quiet", 0, 0, 0, 8'd0, 2'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_breakpoint();
    t_prot_sweep();
    t_v86_real();
    t_stall();
    t_sample_hold();
    t_other();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule